// File: doc/BRIEF.md
# Serial EEPROM Bit-Bang Master

This block lets a host store or fetch a single byte in a small serial EEPROM over a four-wire bit-serial link. The host raises a one-cycle start strobe together with a direction flag, a 6-bit location and, for stores, an 8-bit value. The block then runs the whole exchange by itself. It raises busy for the duration and pulses done when the link is idle again. After a fetch, the byte read from the device appears on the read-data output.

On the device side the block drives an active-low chip select and an active-low write enable. The write enable alone tells the device whether the exchange is a store or a fetch; there is no command code in the frame. The block also drives a serial clock that idles high. The data line is bidirectional and is exposed as a separate output, output enable and input. Every frame carries the location bits first and the data bits straight after them, most-significant bit first in both fields. A host-supplied divider sets how many system clocks each half of a serial clock period lasts.

Top module: `sprom_link_master`

## Requirements
- R1: From the start-strobe cycle to the end of the exchange, sel_no is low. Outside an exchange, sel_no and sclk_o are both high. At least one half-period passes between sel_no falling and the first falling edge of sclk_o.
- R2: For a store (rd_i=0), wen_no falls together with sel_no and stays low for the whole exchange. For a fetch (rd_i=1), wen_no stays high throughout.
- R3: Each frame has exactly 14 rising edges of sclk_o. The first six carry addr_i, MSB first, and the next eight carry the data byte, MSB first. sdo_o changes only when sclk_o falls and is stable across each rising edge.
- R4: On a fetch, the block samples sdi_i in the last system cycle of each low clock phase of the eight data bits, MSB first. When done_o pulses, the assembled byte is on rdata_o. A store leaves rdata_o unchanged.
- R5: Each half-period of sclk_o lasts div_i system clocks, and a div_i of 0 acts as 1. busy_o stays high for exactly 30 half-periods per exchange.
- R6: After the last rising edge, sclk_o stays high for one more half-period. Then sel_no and wen_no go high, busy_o falls, and done_o is high for exactly one cycle, with busy_o low in that cycle.
- R7: A start strobe that arrives while busy_o is high starts nothing. rd_i, addr_i, wdata_i and div_i are captured in the start cycle, so later changes to them have no effect on the exchange in progress.
- R8: sdo_oe_o is high while address bits are clocked out, and on a store while data bits are clocked out. It is low during the data bits of a fetch and whenever sel_no is high.
- R9: While rst_ni is low: sel_no=1, wen_no=1, sclk_o=1, sdo_oe_o=0, busy_o=0, done_o=0, rdata_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Start strobe |
| rd_i | input | 1 | 1 = fetch, 0 = store |
| addr_i | input | 6 | Device location |
| wdata_i | input | 8 | Byte to store |
| div_i | input | 8 | Half-period length in system clocks (0 acts as 1) |
| rdata_o | output | 8 | Last fetched byte |
| busy_o | output | 1 | Exchange in progress |
| done_o | output | 1 | One-cycle end-of-exchange pulse |
| sel_no | output | 1 | Device select, active low |
| wen_no | output | 1 | Device write enable, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Serial data output enable |
| sdi_i | input | 1 | Serial data in |

## Verification
The assertions check the following on every cycle:
- the idle pin levels and the idle output enable;
- that write enable is only ever active inside a select window and holds steady across an exchange;
- that output data is stable at every rising serial clock edge;
- that done is a single-cycle pulse that follows busy.

The remaining behaviours can only be shown by the bench's scenarios, which use a device model driven by the pins:
- the frame contents and bit order;
- the fetch sampling point and the returned byte;
- the exchange length for several divider values, including zero;
- that mid-exchange strobes and input changes have no effect.

// File: rtl/sprom_pkg.sv
package sprom_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_LOW,
    PH_HIGH,
    PH_TAIL
  } ph_e;
endpackage

// File: rtl/sprom_tick.sv
// Half-period timer: end_o marks the last system cycle of each serial half-period.
module sprom_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             end_o
);
  logic [DIV_W-1:0] cnt_q;

  assign end_o = run_i && (cnt_q == half_i - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || end_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/sprom_shift.sv
// Frame shifter: outgoing address+data bits, bit index, incoming byte.
module sprom_shift #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  localparam int FRAME_W = ADDR_W + DATA_W,
  localparam int IDX_W   = $clog2(FRAME_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              adv_i,
  input  logic              smp_i,
  input  logic              sdi_i,
  input  logic              commit_i,
  output logic              bit_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [FRAME_W-1:0] sh_q;
  logic [DATA_W-1:0]  rx_q;

  assign bit_o = sh_q[FRAME_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      idx_o <= '0;
    end else if (load_i) begin
      sh_q  <= {addr_i, wdata_i};
      idx_o <= '0;
    end else if (adv_i) begin
      sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
      idx_o <= idx_o + IDX_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q    <= '0;
      rdata_o <= '0;
    end else begin
      if (smp_i)    rx_q    <= {rx_q[DATA_W-2:0], sdi_i};
      if (commit_i) rdata_o <= rx_q;
    end
  end
endmodule

// File: rtl/sprom_link_master.sv
module sprom_link_master
  import sprom_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              sel_no,
  output logic              wen_no,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic              sdi_i
);
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int IDX_W   = $clog2(FRAME_W + 1);

  ph_e              ph_q, ph_d;
  logic             rd_q;
  logic [DIV_W-1:0] half_q;
  logic             done_q;
  logic             tick;
  logic [IDX_W-1:0] idx;
  logic             tx_bit;
  logic             start, adv, smp, commit, data_ph, active;

  assign active  = (ph_q != PH_IDLE);
  assign start   = !active && go_i;
  assign data_ph = int'(idx) >= ADDR_W;
  assign adv     = (ph_q == PH_HIGH) && tick;
  assign smp     = (ph_q == PH_LOW) && tick && rd_q && data_ph;
  assign commit  = (ph_q == PH_TAIL) && tick && rd_q;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:  if (go_i) ph_d = PH_SETUP;
      PH_SETUP: if (tick) ph_d = PH_LOW;
      PH_LOW:   if (tick) ph_d = PH_HIGH;
      PH_HIGH:  if (tick) ph_d = (idx == IDX_W'(FRAME_W - 1)) ? PH_TAIL : PH_LOW;
      PH_TAIL:  if (tick) ph_d = PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      rd_q   <= 1'b0;
      half_q <= DIV_W'(1);
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      done_q <= (ph_q == PH_TAIL) && tick;
      if (start) begin
        rd_q   <= rd_i;
        half_q <= (div_i == '0) ? DIV_W'(1) : div_i;
      end
    end
  end

  sprom_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (active),
    .half_i (half_q),
    .end_o  (tick)
  );

  sprom_shift #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .adv_i    (adv),
    .smp_i    (smp),
    .sdi_i    (sdi_i),
    .commit_i (commit),
    .bit_o    (tx_bit),
    .idx_o    (idx),
    .rdata_o  (rdata_o)
  );

  // Drive the line only for address bits, and for data bits on a store.
  assign sdo_oe_o = ((ph_q == PH_LOW) || (ph_q == PH_HIGH)) && (!data_ph || !rd_q);
  assign sdo_o    = sdo_oe_o & tx_bit;
  assign sclk_o   = (ph_q != PH_LOW);
  assign sel_no   = !active;
  assign wen_no   = !(active && !rd_q);
  assign busy_o   = active;
  assign done_o   = done_q;
endmodule

// File: rtl/sprom_link_chk.sv
module sprom_link_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sel_no,
  input logic wen_no,
  input logic sclk_o,
  input logic sdo_o,
  input logic sdo_oe_o,
  input logic busy_o,
  input logic done_o
);
  p_idle_clk_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_no |-> sclk_o);
  p_sel_busy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sel_no) |-> busy_o);
  p_wen_in_sel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wen_no |-> !sel_no);
  p_wen_steady_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(wen_no));
  p_sdo_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sclk_o) && sdo_oe_o) |-> $stable(sdo_o));
  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_after_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  p_oe_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_no |-> !sdo_oe_o);
endmodule

bind sprom_link_master sprom_link_chk u_chk (.*);

// File: tb/sim_sprom_link_master.sv
module sim_sprom_link_master;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       go_i = 1'b0, rd_i = 1'b0;
  logic [5:0] addr_i = '0;
  logic [7:0] wdata_i = '0, div_i = 8'd1;
  logic [7:0] rdata_o;
  logic       busy_o, done_o, sel_no, wen_no, sclk_o, sdo_o, sdo_oe_o;
  logic       sdi_i = 1'b0;

  int total = 0, bad = 0;

  always #2 clk_i = ~clk_i;

  sprom_link_master u0 (.*);

  // Device model driven purely by the pins.
  logic [7:0] dev_mem [64];
  logic [7:0] exp_mem [64];
  int         dev_bit = 0, dev_frames = 0, oe_bad = 0;
  logic [5:0] dev_addr = '0;
  logic [7:0] dev_wd = '0;
  logic       dev_wr = 1'b0;

  always @(negedge sel_no) begin
    dev_bit = 0;
    oe_bad  = 0;
  end

  always @(posedge sclk_o) if (!sel_no) begin
    if (dev_bit == 0) dev_wr = !wen_no;
    if (dev_bit < 6) begin
      dev_addr = {dev_addr[4:0], sdo_o};
      if (!sdo_oe_o) oe_bad++;
    end else if (dev_wr) begin
      dev_wd = {dev_wd[6:0], sdo_o};
      if (!sdo_oe_o) oe_bad++;
    end else if (sdo_oe_o) oe_bad++;
    dev_bit++;
  end

  always @(negedge sclk_o)
    if (!sel_no && !dev_wr && dev_bit >= 6 && dev_bit < 14)
      sdi_i = dev_mem[dev_addr][13 - dev_bit];

  always @(posedge sel_no) begin
    if (dev_wr && dev_bit == 14) dev_mem[dev_addr] = dev_wd;
    dev_frames++;
  end

  function automatic int exp_cycles(input logic [7:0] d);
    return 30 * ((d == 0) ? 1 : int'(d));
  endfunction

  task automatic chk(input string req, input logic ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic txn(input logic rd, input logic [5:0] a, input logic [7:0] wd,
                     input logic [7:0] dv, input logic poke);
    int cyc = 0, fr0;
    logic [7:0] rd_before;
    fr0       = dev_frames;
    rd_before = rdata_o;
    @(negedge clk_i);
    go_i = 1'b1; rd_i = rd; addr_i = a; wdata_i = wd; div_i = dv;
    @(negedge clk_i);
    go_i = 1'b0;
    while (!done_o) begin
      if (busy_o) cyc++;
      if (poke && cyc == 5) begin
        // R7: strobe and new inputs while busy
        go_i = 1'b1; rd_i = ~rd; addr_i = ~a; wdata_i = ~wd; div_i = dv + 8'd3;
      end else go_i = 1'b0;
      @(negedge clk_i);
    end
    go_i = 1'b0;
    chk("R5 busy length", cyc == exp_cycles(dv), cyc, exp_cycles(dv));
    chk("R6 busy low at done", !busy_o && sel_no && wen_no, busy_o, 0);
    chk("R3 edges per frame", dev_bit == 14, dev_bit, 14);
    chk("R2 write enable level", dev_wr == !rd, dev_wr, !rd);
    chk("R8 output enable", oe_bad == 0, oe_bad, 0);
    if (rd) begin
      chk("R4 fetched byte", rdata_o == exp_mem[a], rdata_o, exp_mem[a]);
    end else begin
      exp_mem[a] = wd;
      chk("R3 stored byte", dev_mem[a] == wd, dev_mem[a], wd);
      chk("R4 rdata unchanged on store", rdata_o == rd_before, rdata_o, rd_before);
    end
    @(negedge clk_i);
    chk("R6 done one cycle", !done_o, done_o, 0);
    repeat (3) @(negedge clk_i);
    chk("R7 single frame", dev_frames == fr0 + 1 && !busy_o, dev_frames - fr0, 1);
    if (poke) chk("R7 other location untouched", dev_mem[~a] == exp_mem[~a],
                  dev_mem[~a], exp_mem[~a]);
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed = 17;
    void'($urandom(seed));
    for (int i = 0; i < 64; i++) begin
      dev_mem[i] = 8'(i * 37 + 5);
      exp_mem[i] = 8'(i * 37 + 5);
    end
    repeat (3) @(negedge clk_i);
    chk("R9 reset pins", sel_no && wen_no && sclk_o && !sdo_oe_o, sel_no, 1);
    chk("R9 reset status", !busy_o && !done_o && rdata_o == 0, rdata_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // directed corners
    txn(1'b0, 6'h3f, 8'h81, 8'd1, 1'b0);
    txn(1'b1, 6'h3f, 8'h00, 8'd0, 1'b0);   // R5: divider zero
    txn(1'b1, 6'h00, 8'h00, 8'd3, 1'b0);
    txn(1'b0, 6'h15, 8'hA5, 8'd2, 1'b1);   // R7
    txn(1'b1, 6'h15, 8'h5A, 8'd2, 1'b1);   // R7 on fetch
    for (int i = 0; i < 40; i++)
      txn(1'($urandom), 6'($urandom), 8'($urandom), 8'($urandom_range(0, 4)),
          1'($urandom_range(0, 3) == 0));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule